// File: doc/BRIEF.md
# Key-Protected Media Converter Configuration Registers

This block is the register front end of a four-port media interface converter. It sits on a simple synchronous register bus and holds the configuration that the rest of the converter uses: a switch-mode field, one control word per converter port, and two switch control words. The switch-mode field is decoded, without any clock delay, into a per-port source code and a valid bit. Together these drive an external routing mux that connects each converter port to a MAC, a fieldbus controller port or a switch port.

All configuration registers are write-protected. Software opens them by writing a four-word key to the protection command register at offset 0x0, with no other write in between. A later write to that register closes them again. A write to a protected register while the block is locked is dropped without any error. Reads are always allowed. Read data is registered, so it appears one cycle after the read strobe.

Top module: `conv_cfg_regs`

## Requirements
- R1: After reset every register is zero. The block is locked and the mode is 0, so route_sel is 16'h1876 and route_vld is 4'hF.
- R2: Writing 0x00A5, 0x0001, 0xFFFE and 0x0001 to offset 0x0 as four consecutive bus writes unlocks the block. The unlocked state takes effect after the fourth write and not before it.
- R3: While locked, a write to offset 0x0 that does not match the next expected key word returns the key tracker to its start. If that word is 0x00A5, it counts as the first key word of a new attempt.
- R4: A write to any address other than 0x0 while a key attempt is in progress abandons the attempt.
- R5: While unlocked, any write to offset 0x0 locks the block. The usual relock value is 0x0000. A value of 0x00A5 locks the block and also starts a new key attempt.
- R6: While locked, writes to the mode register (0x008), the converter control words (0x100 + 4*p, p = 0..3), the switch control word (0x304) and the switch duplex word (0x308) have no effect.
- R7: While unlocked, writes to those registers take effect in the next cycle. The mode register keeps only wr_data[2:0]. Converter word p drives conv_ctrl[32*p+31:32*p].
- R8: A read strobe returns the addressed register on rd_data one cycle later, locked or not. Offset 0x0 reads as bit 0 = unlocked state with all other bits zero. The mode register reads back zero-extended. Unmapped addresses read as zero. rd_data holds its value when no read is strobed.
- R9: route_sel holds one 4-bit source code per port, with port p at bits [4p+3:4p]. The codes are MAC0..2 = 0..2, fieldbus0..2 = 3..5 and switch0..2 = 6..8. For ports 0..3 the modes give: 0 = sw0,sw1,sw2,MAC1; 1 = fb0,fb1,MAC2,MAC1; 2 = fb0,fb1,sw2,MAC1; 3 = fb0,fb1,fb2,MAC1; 4 = sw0,fb1,fb2,MAC1; 5 = sw0,fb1,sw2,MAC1; 6 = sw0,sw1,MAC2,MAC1; 7 = MAC0,MAC1,MAC2,none.
- R10: An unconnected port shows code 4'hF with its route_vld bit low. This happens only for port 3 in mode 7; in every other case all four valid bits are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| route_sel | output | 16 | Per-port source code for the routing mux |
| route_vld | output | 4 | Per-port connection valid |
| conv_ctrl | output | 128 | Per-port converter control words |
| sw_ctrl | output | 32 | Switch control word |
| sw_dup | output | 32 | Switch duplex control word |

## Verification
The routing decode is run through all eight mode values. Each value is written under a full unlock and relock, and both the routing outputs and the mode readback are compared. This shows the decode table and the write path are correct for every mode, and that the relock leaves the mode in place. The key tracker gets several command streams: a clean key, a key broken by a wrong word, a key broken by a write to another register, and a key that begins with a doubled 0x00A5. These separate a full reset of the tracker from a restart at step one. Protected writes are tried both locked and unlocked against the same registers, so that a dropped write can be told apart from a write that went to the wrong place.

// File: rtl/conv_cfg_regs.sv
module conv_cfg_regs #(
  parameter int DW = 32,
  parameter int AW = 12,
  parameter int NP = 4,
  parameter int MW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  output logic [DW-1:0]   rd_data,
  output logic [4*NP-1:0] route_sel,
  output logic [NP-1:0]   route_vld,
  output logic [NP*DW-1:0] conv_ctrl,
  output logic [DW-1:0]   sw_ctrl,
  output logic [DW-1:0]   sw_dup
);
  localparam logic [AW-1:0] A_CMD  = AW'('h000);
  localparam logic [AW-1:0] A_MODE = AW'('h008);
  localparam logic [AW-1:0] A_CONV = AW'('h100);
  localparam logic [AW-1:0] A_SWC  = AW'('h304);
  localparam logic [AW-1:0] A_SWD  = AW'('h308);
  localparam logic [DW-1:0] K_START = DW'('h00A5);

  logic [1:0]    step_q;
  logic          unl_q;
  logic [MW-1:0] mode_q;
  logic [DW-1:0] conv_q [NP];
  logic [DW-1:0] swc_q, swd_q, rd_q, rd_mux;
  logic [NP-1:0] conv_hit;

  function automatic logic [DW-1:0] key_word(input logic [1:0] s);
    case (s)
      2'd0: key_word = DW'('h00A5);
      2'd1: key_word = DW'('h0001);
      2'd2: key_word = DW'('hFFFE);
      default: key_word = DW'('h0001);
    endcase
  endfunction

  wire cmd_wr  = wr_en && (addr == A_CMD);
  wire prot_wr = wr_en && unl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= '0;
      unl_q  <= 1'b0;
    end else if (cmd_wr) begin
      if (unl_q) begin
        unl_q  <= 1'b0;
        step_q <= (wr_data == K_START) ? 2'd1 : 2'd0;
      end else if (wr_data == key_word(step_q)) begin
        if (step_q == 2'd3) begin
          unl_q  <= 1'b1;
          step_q <= 2'd0;
        end else begin
          step_q <= step_q + 2'd1;
        end
      end else begin
        step_q <= (wr_data == K_START) ? 2'd1 : 2'd0;
      end
    end else if (wr_en) begin
      step_q <= 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      swc_q  <= '0;
      swd_q  <= '0;
    end else if (prot_wr) begin
      if (addr == A_MODE) mode_q <= wr_data[MW-1:0];
      if (addr == A_SWC)  swc_q  <= wr_data;
      if (addr == A_SWD)  swd_q  <= wr_data;
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_conv
    assign conv_hit[p] = (addr == A_CONV + AW'(4*p));
    always_ff @(posedge clk) begin
      if (!rst_n)                    conv_q[p] <= '0;
      else if (prot_wr && conv_hit[p]) conv_q[p] <= wr_data;
    end
    assign conv_ctrl[DW*p +: DW] = conv_q[p];
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_CMD)  rd_mux = DW'(unl_q);
    if (addr == A_MODE) rd_mux = DW'(mode_q);
    if (addr == A_SWC)  rd_mux = swc_q;
    if (addr == A_SWD)  rd_mux = swd_q;
    for (int p = 0; p < NP; p++)
      if (conv_hit[p]) rd_mux = conv_q[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end
  assign rd_data = rd_q;

  always_comb begin
    route_vld = '1;
    case (mode_q[2:0])
      3'd0: route_sel = 16'h1876;
      3'd1: route_sel = 16'h1243;
      3'd2: route_sel = 16'h1843;
      3'd3: route_sel = 16'h1543;
      3'd4: route_sel = 16'h1546;
      3'd5: route_sel = 16'h1846;
      3'd6: route_sel = 16'h1276;
      default: begin
        route_sel = 16'hF210;
        route_vld = 4'b0111;
      end
    endcase
  end
  assign sw_ctrl = swc_q;
  assign sw_dup  = swd_q;

  a_r2_unlock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(cmd_wr) && $past(wr_data) == DW'('h0001));
  a_r5_relock: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && unl_q |=> !unl_q);
  a_r6_locked_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !unl_q |=> $stable(mode_q) && $stable(swc_q) && $stable(swd_q));
  a_r8_cmd_readback: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == A_CMD |=> rd_data == DW'($past(unl_q)));
  a_r8_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  a_r10_vld_only_mode7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[2:0] != 3'd7 |-> route_vld == 4'hF);
endmodule

// File: tb/test_conv_cfg_regs.sv
module test_conv_cfg_regs;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [11:0]  addr = '0;
  logic         wr_en = 0;
  logic [31:0]  wr_data = '0;
  logic         rd_en = 0;
  logic [31:0]  rd_data;
  logic [15:0]  route_sel;
  logic [3:0]   route_vld;
  logic [127:0] conv_ctrl;
  logic [31:0]  sw_ctrl, sw_dup;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  conv_cfg_regs i_conv_cfg_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .route_sel(route_sel), .route_vld(route_vld),
    .conv_ctrl(conv_ctrl), .sw_ctrl(sw_ctrl), .sw_dup(sw_dup));

  // {route_sel, route_vld} per mode 0..7
  localparam logic [19:0] EXP [0:7] = '{
    20'h1876F, 20'h1243F, 20'h1843F, 20'h1543F,
    20'h1546F, 20'h1846F, 20'h1276F, 20'hF2107};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic unlock();
    wr(12'h000, 32'h00A5); wr(12'h000, 32'h0001);
    wr(12'h000, 32'hFFFE); wr(12'h000, 32'h0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 route", {route_sel, route_vld}, 20'h1876F);
    chk("R1 conv", conv_ctrl, '0);
    chk("R1 sw", {sw_ctrl, sw_dup}, '0);
    rd(12'h000, d); chk("R1 locked", d, 0);
    rd(12'h008, d); chk("R1 mode", d, 0);

    // R9 R10 R7 table walk
    for (int m = 0; m < 8; m++) begin
      unlock();
      wr(12'h008, 32'(m));
      wr(12'h000, 32'h0000);
      chk("R9/R10 route", {route_sel, route_vld}, EXP[m]);
      rd(12'h008, d); chk("R7/R8 mode read", d, 32'(m));
    end

    // R6 locked writes dropped
    wr(12'h008, 32'h2);
    chk("R6 mode", {route_sel, route_vld}, 20'hF2107);
    wr(12'h100, 32'h12345678);
    wr(12'h304, 32'hAAAA5555);
    wr(12'h308, 32'h1);
    chk("R6 conv", conv_ctrl, '0);
    chk("R6 sw", {sw_ctrl, sw_dup}, '0);

    // R2 unlock timing
    wr(12'h000, 32'h00A5); wr(12'h000, 32'h0001); wr(12'h000, 32'hFFFE);
    rd(12'h000, d); chk("R2 after 3 keys", d, 0);
    wr(12'h000, 32'h0001);
    rd(12'h000, d); chk("R2 after 4 keys", d, 1);

    // R7 unlocked writes
    wr(12'h108, 32'hDEADBEEF);
    wr(12'h10C, 32'h0BADF00D);
    wr(12'h304, 32'hCAFE0001);
    wr(12'h308, 32'h00000003);
    wr(12'h008, 32'hFFFFFFF9);
    chk("R7 conv", conv_ctrl, {32'h0BADF00D, 32'hDEADBEEF, 64'h0});
    chk("R7 sw", {sw_ctrl, sw_dup}, {32'hCAFE0001, 32'h3});
    chk("R7 mode low bits", {route_sel, route_vld}, 20'h1243F);
    rd(12'h108, d); chk("R8 conv read", d, 32'hDEADBEEF);
    rd(12'h008, d); chk("R8 mode zero-ext", d, 32'h1);

    // R5 relock by 0 and by other value
    wr(12'h000, 32'h0000);
    rd(12'h000, d); chk("R5 relock 0", d, 0);
    rd(12'h10C, d); chk("R8 read locked", d, 32'h0BADF00D);
    rd(12'h010, d); chk("R8 unmapped", d, 0);
    unlock();
    wr(12'h000, 32'h0077);
    rd(12'h000, d); chk("R5 relock other", d, 0);
    // R5: A5 while unlocked starts a new attempt
    unlock();
    wr(12'h000, 32'h00A5); wr(12'h000, 32'h0001);
    wr(12'h000, 32'hFFFE); wr(12'h000, 32'h0001);
    rd(12'h000, d); chk("R5 A5 relock restarts", d, 1);
    wr(12'h000, 32'h0000);

    // R3 wrong word resets
    wr(12'h000, 32'h00A5); wr(12'h000, 32'h0001); wr(12'h000, 32'h1234);
    wr(12'h000, 32'hFFFE); wr(12'h000, 32'h0001);
    rd(12'h000, d); chk("R3 broken key", d, 0);
    wr(12'h000, 32'h00A5); wr(12'h000, 32'h00A5); wr(12'h000, 32'h0001);
    wr(12'h000, 32'hFFFE); wr(12'h000, 32'h0001);
    rd(12'h000, d); chk("R3 A5 restart", d, 1);
    wr(12'h000, 32'h0000);

    // R4 intervening write abandons attempt
    wr(12'h000, 32'h00A5); wr(12'h000, 32'h0001);
    wr(12'h008, 32'h5);
    wr(12'h000, 32'hFFFE); wr(12'h000, 32'h0001);
    rd(12'h000, d); chk("R4 interrupted key", d, 0);
    chk("R4 mode untouched", {route_sel, route_vld}, 20'h1243F);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule